// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel NOR flash. A local requester issues one of four operations: a plain byte read, a byte program, a sector erase or a full-chip erase. The block turns each request into the bus cycles the flash expects. Each bus cycle drives chip enable, output enable, write enable, the address and the data, and every timing window is counted in clock cycles.

For a program or an erase, the block first writes the fixed unlock/command sequence. It then reads the target location over and over. While the embedded algorithm runs, the flash returns the inverse of the final bit 7. Once that bit reads back true, the block reports completion. If polling lasts longer than a per-operation clock budget, the block reports completion with an error flag and returns to idle.

The requester presents a request while `req_ready` is high. The block raises `done` for one cycle when it finishes. On a read, `rd_data` holds the byte that was read.

Top module: `nor_cmd_seq`

## Requirements
- R1: A program request (op code 1) produces exactly four write cycles, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (target address, request data).
- R2: A sector erase request (op code 2) produces six write cycles: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then 30h written to the sector base. The sector base is the request address with its top 3 bits kept and all lower bits cleared.
- R3: A chip erase request (op code 3) produces the same first five cycles as R2, and its sixth cycle writes 10h to 5555h.
- R4: Write enable goes low only while chip enable is low. Each low pulse lasts exactly T_PULSE clocks. Address and write data stay constant throughout the pulse.
- R5: The data bus output enable is asserted only during write cycles. It is never asserted while the flash output enable is low, and it is deasserted whenever the block is idle.
- R6: After a program or erase, the block polls the target location (the sector base for a sector erase). It reports `done` with `err` low only after bit 7 of a read matches the expected final bit 7: the request data bit 7 for a program, 1 for an erase. While the flash reports busy, no `done` is produced.
- R7: If polling has not succeeded after PROG_TO clocks (program) or ERASE_TO clocks (erase), `done` and `err` rise together in the same cycle and the block returns to idle.
- R8: A read request (op code 0) performs a single read cycle with no write cycle. It presents the flash byte on `rd_data` in the cycle `done` is high, with `err` low.
- R9: During and right after reset, chip enable, output enable and write enable are high, the data bus output enable is low, `req_ready` is high, and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | DATA_W | Byte to program |
| req_ready | output | 1 | Block idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rd_data | output | DATA_W | Byte returned by a read request |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_o | output | DATA_W | Data driven to the flash |
| fl_dq_oe | output | 1 | Data bus drive enable |
| fl_dq_i | input | DATA_W | Data read from the flash |

## Verification
The bench's flash model latches the address on each write-enable fall and the data on each rise. It then checks the full captured command list against the expected unlock pattern for each operation. A wrong unlock constant, a swapped step, or an unmasked sector address therefore shows up as a list mismatch.

Programs with bit 7 set and with bit 7 clear check the poll comparison polarity. An inverted comparison would either finish while the model still reports busy or never finish.

A flash model that never completes checks that the error arrives within a bounded window after the last write, rather than hanging or arriving early. Every clock, a monitor checks pulse widths and bus-drive overlap.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } nor_op_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nor_cmd_step.sv
module nor_cmd_step
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int SECT_BITS = 3
) (
  input  nor_op_e            op,
  input  logic [2:0]         step,
  input  logic [ADDR_W-1:0]  tgt_addr,
  input  logic [DATA_W-1:0]  tgt_data,
  output logic [ADDR_W-1:0]  cyc_addr,
  output logic [DATA_W-1:0]  cyc_data,
  output logic               cyc_last,
  output logic [ADDR_W-1:0]  sect_base
);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(16'h2AAA);
  localparam logic [ADDR_W-1:0] SECT_MASK =
    {{SECT_BITS{1'b1}}, {(ADDR_W-SECT_BITS){1'b0}}};

  assign sect_base = tgt_addr & SECT_MASK;

  always_comb begin
    cyc_addr = KEY_A;
    cyc_data = DATA_W'(8'hAA);
    cyc_last = 1'b0;
    if (op == OP_PROG) begin
      case (step)
        3'd0: begin cyc_addr = KEY_A; cyc_data = DATA_W'(8'hAA); end
        3'd1: begin cyc_addr = KEY_B; cyc_data = DATA_W'(8'h55); end
        3'd2: begin cyc_addr = KEY_A; cyc_data = DATA_W'(8'hA0); end
        default: begin
          cyc_addr = tgt_addr;
          cyc_data = tgt_data;
          cyc_last = 1'b1;
        end
      endcase
    end else begin
      case (step)
        3'd0: begin cyc_addr = KEY_A; cyc_data = DATA_W'(8'hAA); end
        3'd1: begin cyc_addr = KEY_B; cyc_data = DATA_W'(8'h55); end
        3'd2: begin cyc_addr = KEY_A; cyc_data = DATA_W'(8'h80); end
        3'd3: begin cyc_addr = KEY_A; cyc_data = DATA_W'(8'hAA); end
        3'd4: begin cyc_addr = KEY_B; cyc_data = DATA_W'(8'h55); end
        default: begin
          cyc_last = 1'b1;
          if (op == OP_SECT) begin
            cyc_addr = sect_base;
            cyc_data = DATA_W'(8'h30);
          end else begin
            cyc_addr = KEY_A;
            cyc_data = DATA_W'(8'h10);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nor_bus_phy.sv
module nor_bus_phy
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int T_SETUP  = 2,
  parameter int T_PULSE  = 3,
  parameter int T_HOLD   = 2,
  parameter int T_ACCESS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] fl_dq_i,
  output logic              cyc_done,
  output logic [DATA_W-1:0] rdata,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe
);
  localparam int TMAX  = imax(imax(T_SETUP, T_PULSE), imax(T_HOLD, T_ACCESS));
  localparam int CNT_W = $clog2(TMAX + 1);

  typedef enum logic [2:0] {
    B_IDLE, B_SETUP, B_PULSE, B_HOLD, B_RACC, B_RREC
  } bus_st_e;

  bus_st_e            st;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      cyc_done <= 1'b0;
      rdata    <= '0;
      fl_ce_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_addr  <= '0;
      fl_dq_o  <= '0;
      fl_dq_oe <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          fl_addr <= addr;
          fl_ce_n <= 1'b0;
          if (is_wr) begin
            fl_dq_o  <= wdata;
            fl_dq_oe <= 1'b1;
            cnt      <= CNT_W'(T_SETUP - 1);
            st       <= B_SETUP;
          end else begin
            fl_oe_n <= 1'b0;
            cnt     <= CNT_W'(T_ACCESS - 1);
            st      <= B_RACC;
          end
        end
        B_SETUP: if (cnt == '0) begin
          fl_we_n <= 1'b0;
          cnt     <= CNT_W'(T_PULSE - 1);
          st      <= B_PULSE;
        end else cnt <= cnt - 1'b1;
        B_PULSE: if (cnt == '0) begin
          fl_we_n <= 1'b1;
          cnt     <= CNT_W'(T_HOLD - 1);
          st      <= B_HOLD;
        end else cnt <= cnt - 1'b1;
        B_HOLD: if (cnt == '0) begin
          fl_dq_oe <= 1'b0;
          fl_ce_n  <= 1'b1;
          cyc_done <= 1'b1;
          st       <= B_IDLE;
        end else cnt <= cnt - 1'b1;
        B_RACC: if (cnt == '0) begin
          rdata   <= fl_dq_i;
          fl_oe_n <= 1'b1;
          cnt     <= CNT_W'(T_HOLD - 1);
          st      <= B_RREC;
        end else cnt <= cnt - 1'b1;
        B_RREC: if (cnt == '0) begin
          fl_ce_n  <= 1'b1;
          cyc_done <= 1'b1;
          st       <= B_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int PROG_TO  = 12500,
  parameter int ERASE_TO = 250000000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic is_erase,
  output logic expired
);
  localparam int LIM_MAX = (PROG_TO > ERASE_TO) ? PROG_TO : ERASE_TO;
  localparam int TW      = $clog2(LIM_MAX + 1);

  logic [TW-1:0] ticks;
  logic [TW-1:0] limit;

  assign limit   = is_erase ? TW'(ERASE_TO) : TW'(PROG_TO);
  assign expired = (ticks >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr) ticks <= '0;
    else if (run && !expired) ticks <= ticks + 1'b1;
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int SECT_BITS = 3,
  parameter int T_SETUP   = 2,
  parameter int T_PULSE   = 3,
  parameter int T_HOLD    = 2,
  parameter int T_ACCESS  = 3,
  parameter int PROG_TO   = 12500,
  parameter int ERASE_TO  = 250000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_i
);
  typedef enum logic [1:0] { S_IDLE, S_ISSUE, S_WAIT } seq_st_e;

  seq_st_e            st;
  nor_op_e            op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [2:0]         step_q;
  logic               polling;
  logic               tmr_clr;

  logic               phy_start, phy_wr, phy_done;
  logic [ADDR_W-1:0]  phy_addr;
  logic [DATA_W-1:0]  phy_wdata, phy_rdata;

  logic [ADDR_W-1:0]  c_addr, sect_base, poll_addr;
  logic [DATA_W-1:0]  c_data;
  logic               c_last, tmr_exp, expect_b7, reads_only;

  nor_cmd_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_BITS(SECT_BITS)) u_step (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .cyc_addr(c_addr), .cyc_data(c_data), .cyc_last(c_last), .sect_base(sect_base)
  );

  nor_bus_phy #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_SETUP(T_SETUP),
                .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_ACCESS(T_ACCESS)) u_phy (
    .clk(clk), .rst(rst), .start(phy_start), .is_wr(phy_wr), .addr(phy_addr),
    .wdata(phy_wdata), .fl_dq_i(fl_dq_i), .cyc_done(phy_done), .rdata(phy_rdata),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe)
  );

  nor_poll_timer #(.PROG_TO(PROG_TO), .ERASE_TO(ERASE_TO)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(polling),
    .is_erase(op_q != OP_PROG), .expired(tmr_exp)
  );

  assign poll_addr  = (op_q == OP_SECT) ? sect_base : addr_q;
  assign expect_b7  = (op_q == OP_PROG) ? data_q[DATA_W-1] : 1'b1;
  assign reads_only = (op_q == OP_READ) || polling;
  assign req_ready  = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_READ;
      addr_q    <= '0;
      data_q    <= '0;
      step_q    <= '0;
      polling   <= 1'b0;
      tmr_clr   <= 1'b0;
      phy_start <= 1'b0;
      phy_wr    <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      rd_data   <= '0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      tmr_clr <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= nor_op_e'(req_op);
          addr_q  <= req_addr;
          data_q  <= req_data;
          step_q  <= '0;
          polling <= 1'b0;
          st      <= S_ISSUE;
        end
        S_ISSUE: begin
          phy_start <= 1'b1;
          phy_wr    <= !reads_only;
          phy_addr  <= reads_only ? poll_addr : c_addr;
          phy_wdata <= c_data;
          st        <= S_WAIT;
        end
        S_WAIT: begin
          phy_start <= 1'b0;
          if (phy_done) begin
            if (op_q == OP_READ) begin
              rd_data <= phy_rdata;
              done    <= 1'b1;
              st      <= S_IDLE;
            end else if (!polling) begin
              if (c_last) begin
                polling <= 1'b1;
                tmr_clr <= 1'b1;
              end else begin
                step_q <= step_q + 1'b1;
              end
              st <= S_ISSUE;
            end else if (phy_rdata[DATA_W-1] == expect_b7) begin
              polling <= 1'b0;
              done    <= 1'b1;
              st      <= S_IDLE;
            end else if (tmr_exp) begin
              polling <= 1'b0;
              done    <= 1'b1;
              err     <= 1'b1;
              st      <= S_IDLE;
            end else begin
              st <= S_ISSUE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq_sva.sv
module nor_cmd_seq_sva #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic              err,
  input logic              fl_ce_n,
  input logic              fl_oe_n,
  input logic              fl_we_n,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [DATA_W-1:0] fl_dq_o,
  input logic              fl_dq_oe
);
  assert_we_needs_ce_R4: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n);

  assert_pulse_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

  assert_no_bus_fight_R5: assert property (@(posedge clk) disable iff (rst)
    fl_dq_oe |-> fl_oe_n);

  assert_read_not_write_R5: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> fl_we_n);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (fl_ce_n && !fl_dq_oe));

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
endmodule

bind nor_cmd_seq nor_cmd_seq_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst(rst), .req_ready(req_ready), .done(done), .err(err),
  .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
  .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int TP = 3;
  localparam int PTO = 400;
  localparam int ETO = 1500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, err;
  logic [DW-1:0] rd_data;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o;
  logic [DW-1:0] fl_dq_i;

  always #4 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .SECT_BITS(3), .T_SETUP(2), .T_PULSE(TP),
                .T_HOLD(2), .T_ACCESS(3), .PROG_TO(PTO), .ERASE_TO(ETO)) u_nor_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready), .done(done), .err(err), .rd_data(rd_data),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  // flash model state
  logic [AW-1:0] cap_a[$];
  logic [DW-1:0] cap_d[$];
  logic [AW-1:0] lat_a;
  int  exp_n = 0;
  int  busy_len = 0;
  int  busy_cnt = 0;
  int  last_we_cyc = 0;
  bit  timeout_case = 0;
  logic [DW-1:0] final_val = 8'h00;

  assign fl_dq_i = fl_oe_n ? 8'h00 :
                   (busy_cnt > 0) ? {~final_val[7], 7'h15} : final_val;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge fl_we_n) if (!rst) lat_a = fl_addr;
  always @(posedge fl_we_n) if (!rst) begin
    cap_a.push_back(lat_a);
    cap_d.push_back(fl_dq_o);
    last_we_cyc = cyc;
    if (cap_a.size() == exp_n) busy_cnt = busy_len;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // per-clock monitor
  int we_low = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
      // R5: never drive data while flash drives the bus
      chk(!(fl_dq_oe && !fl_oe_n), "R5", "dq_oe with oe_n low", fl_dq_oe, 0);
      // R6: no completion while the model still reports busy
      if (done && !timeout_case)
        chk(busy_cnt == 0 && !err, "R6", "done while busy or err", busy_cnt, 0);
      if (!fl_we_n) we_low++;
      else if (we_low > 0) begin
        chk(we_low == TP, "R4", "write pulse width", we_low, TP);
        we_low = 0;
      end
    end
  end

  logic [AW-1:0] ex_a[$];
  logic [DW-1:0] ex_d[$];
  logic got_err;
  logic [DW-1:0] got_rd;
  int done_cyc;

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int blen, input logic [DW-1:0] fval, input int n);
    cap_a.delete(); cap_d.delete();
    exp_n = n; busy_len = blen; final_val = fval;
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    got_err = err; got_rd = rd_data; done_cyc = cyc;
    @(negedge clk);
  endtask

  task automatic cmp_list(input string req);
    chk(cap_a.size() == ex_a.size(), req, "write cycle count", cap_a.size(), ex_a.size());
    if (cap_a.size() == ex_a.size())
      foreach (ex_a[i]) begin
        chk(cap_a[i] == ex_a[i], req, $sformatf("addr of cycle %0d", i), cap_a[i], ex_a[i]);
        chk(cap_d[i] == ex_d[i], req, $sformatf("data of cycle %0d", i), cap_d[i], ex_d[i]);
      end
  endtask

  task automatic prep_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ex_a = '{19'h05555, 19'h02AAA, 19'h05555, a};
    ex_d = '{8'hAA, 8'h55, 8'hA0, d};
  endtask

  task automatic prep_erase(input logic [AW-1:0] fa, input logic [DW-1:0] fd);
    ex_a = '{19'h05555, 19'h02AAA, 19'h05555, 19'h05555, 19'h02AAA, fa};
    ex_d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, fd};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R9", "strobes high in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 3'b111);
    chk(!fl_dq_oe && req_ready && !done && !err, "R9", "idle flags in reset",
        {fl_dq_oe, req_ready, done, err}, 4'b0100);
    rst = 1'b0;
    @(negedge clk);
    chk(fl_ce_n && !fl_dq_oe && req_ready, "R9", "idle after reset", {fl_ce_n, fl_dq_oe, req_ready}, 3'b101);

    // R8 plain read
    run_op(2'd0, 19'h01234, 8'h00, 0, 8'h6E, 99);
    chk(got_rd == 8'h6E, "R8", "read data", got_rd, 8'h6E);
    chk(!got_err, "R8", "read err", got_err, 0);
    chk(cap_a.size() == 0, "R8", "no write cycles on read", cap_a.size(), 0);

    // R1 program, bit7 set
    prep_prog(19'h71234, 8'hC3);
    run_op(2'd1, 19'h71234, 8'hC3, 200, 8'hC3, 4);
    cmp_list("R1");
    chk(!got_err, "R6", "program bit7=1 completes without err", got_err, 0);
    chk(done_cyc - last_we_cyc >= 200, "R6", "program done after busy", done_cyc - last_we_cyc, 200);

    // R1/R6 program, bit7 clear
    prep_prog(19'h00ABC, 8'h3C);
    run_op(2'd1, 19'h00ABC, 8'h3C, 150, 8'h3C, 4);
    cmp_list("R1");
    chk(!got_err, "R6", "program bit7=0 completes without err", got_err, 0);
    chk(done_cyc - last_we_cyc >= 150, "R6", "program bit7=0 done after busy", done_cyc - last_we_cyc, 150);

    // R2 sector erase
    prep_erase(19'h50000, 8'h30);
    run_op(2'd2, 19'h5ABCD, 8'h00, 600, 8'hFF, 6);
    cmp_list("R2");
    chk(!got_err, "R6", "sector erase err", got_err, 0);
    chk(done_cyc - last_we_cyc >= 600, "R6", "sector erase done after busy", done_cyc - last_we_cyc, 600);

    // R3 chip erase
    prep_erase(19'h05555, 8'h10);
    run_op(2'd3, 19'h3FFFF, 8'h00, 700, 8'hFF, 6);
    cmp_list("R3");
    chk(!got_err, "R3", "chip erase err", got_err, 0);

    // R7 program timeout: model never completes
    timeout_case = 1;
    prep_prog(19'h12345, 8'h80);
    run_op(2'd1, 19'h12345, 8'h80, 100000, 8'h80, 4);
    cmp_list("R1");
    chk(got_err, "R7", "timeout err flag", got_err, 1);
    chk(done_cyc - last_we_cyc >= PTO && done_cyc - last_we_cyc <= PTO + 30, "R7",
        "timeout latency", done_cyc - last_we_cyc, PTO);
    busy_cnt = 0;
    timeout_case = 0;
    @(negedge clk);
    chk(req_ready && fl_ce_n, "R7", "idle after timeout", {req_ready, fl_ce_n}, 2'b11);

    // R8 read after timeout
    run_op(2'd0, 19'h00010, 8'h00, 0, 8'h91, 99);
    chk(got_rd == 8'h91 && !got_err, "R8", "read after timeout", got_rd, 8'h91);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule